// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets a host manage internal Ethernet PHYs through two 32-bit registers. The host writes a command word that holds a PHY address, a register number, write data and a read or write request. The engine then sends one Clause 22 management frame on a divided management clock. For a read it releases the data line and shifts in the PHY's 16-bit reply. When the frame ends, the engine sets a write-done or read-done flag in a status register. Reading the status register clears these flags.

A host driver reads the status word once before each command, to throw away any stale completion. It then writes the command and polls the status word every few microseconds until the matching done flag appears. At the default divide ratio a frame lasts 2048 system clocks, so it finishes far inside a millisecond-scale poll timeout. Only one frame runs at a time. The engine handles no arbitration between several hosts and no extended (Clause 45) addressing.

Top module: `mdio_cmd_engine`

## Requirements
- R1: A command word with bit 13 set and bit 14 clear starts a write frame. The frame is 32 ones, then 01, opcode 01, PHY address (command bits 4:0), register number (command bits 12:8), turnaround 10, and the write data (command bits 31:16), each field MSB first.
- R2: A command word with bit 14 set starts a read frame. It carries opcode 10 and the same header, and the engine drives the line only for the first 46 bits. The 16 bits sampled in the last 16 bit times land MSB first in status bits 31:16.
- R3: The status word (offset 4) reports write-done in bit 0, read-done in bit 1 and transaction-in-progress in bit 2. Each done flag is set when its frame ends.
- R4: A status read returns the flags and clears both done bits, so the next status read shows them as 0. A flag that is set in the same cycle as the read is kept.
- R5: A command written while a frame is in progress is ignored. No second frame follows, and the stored command word stays unchanged.
- R6: A command word with both bits 13 and 14 set runs a read frame, and the write data it carries is not sent.
- R7: A command word with neither bit 13 nor bit 14 set starts no frame.
- R8: The management clock runs at the system clock divided by CLK_DIV (default 32). Its low and high phases are equal. The data line changes only after a falling edge of the management clock.
- R9: A frame keeps the engine busy for exactly 64 × CLK_DIV system clock cycles. A write frame drives the line for all of those cycles.
- R10: After reset, and whenever no frame is running, the management clock is low and the data line is released. The status word reads 0 after reset.
- R11: A read at the command offset (0) returns the last command word that was accepted, or 0 if none has been accepted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The main internal state is the frame shift register, the bit counter and the clock phase. If the shift register or the bit counter is wrong, the decoded frame seen at the MDIO pins shows a bad header or data field at once, within that same frame. If the counter or the divider is off, a transaction ends early or late, and the cycle count of the output enable reveals this by the end of the frame. If the done flags or the busy state are wrong, the next one or two status reads show it: a flag that never clears, a lost completion, or a second frame started from a command that should have been dropped.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

  localparam int WORD_W     = 32;
  localparam int PHY_W      = 5;
  localparam int REGN_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int DATA_START = FRAME_BITS - DATA_W;   // first data bit index
  localparam int RD_DRIVE   = DATA_START - 2;        // bits driven on a read
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // command word field positions
  localparam int CMD_PHY_LSB  = 0;
  localparam int CMD_REG_LSB  = 8;
  localparam int CMD_WR_BIT   = 13;
  localparam int CMD_RD_BIT   = 14;
  localparam int CMD_DATA_LSB = 16;

  // status word field positions
  localparam int ST_WR_DONE  = 0;
  localparam int ST_RD_DONE  = 1;
  localparam int ST_BUSY     = 2;
  localparam int ST_DATA_LSB = 16;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e          op;
    logic [PHY_W-1:0]  phy;
    logic [REGN_W-1:0] regn;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;

  function automatic mdio_req_t decode_cmd(input logic [WORD_W-1:0] w);
    mdio_req_t r;
    r.phy   = w[CMD_PHY_LSB +: PHY_W];
    r.regn  = w[CMD_REG_LSB +: REGN_W];
    r.wdata = w[CMD_DATA_LSB +: DATA_W];
    if (w[CMD_RD_BIT])      r.op = OP_READ;   // read has priority
    else if (w[CMD_WR_BIT]) r.op = OP_WRITE;
    else                    r.op = OP_NONE;
    return r;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
    logic rd;
    rd = (r.op == OP_READ);
    return {{PRE_BITS{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), r.phy, r.regn,
            (rd ? 2'b00 : 2'b10), (rd ? {DATA_W{1'b0}} : r.wdata)};
  endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = $clog2(DIV);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;

  assign rise_o = run_i && (cnt_q == CNT_W'(HALF - 1));
  assign fall_o = run_i && (cnt_q == CNT_W'(DIV - 1));
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + 1'b1;
      if (rise_o)      mdc_q <= 1'b1;
      else if (fall_o) mdc_q <= 1'b0;
    end
  end

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mdio_req_t         req_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_rd_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q, is_rd_q, done_q;
  logic [DATA_W-1:0]     rdata_q;
  logic                  last_bit;

  assign last_bit  = (idx_q == IDX_W'(FRAME_BITS - 1));
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign done_rd_o = is_rd_q;
  assign rdata_o   = rdata_q;
  assign mdio_o    = sh_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q && (!is_rd_q || (idx_q < IDX_W'(RD_DRIVE)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          sh_q    <= build_frame(req_i);
          idx_q   <= '0;
          is_rd_q <= (req_i.op == OP_READ);
          busy_q  <= 1'b1;
        end
      end else begin
        if (rise_i && is_rd_q && (idx_q >= IDX_W'(DATA_START)))
          rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
        if (fall_i) begin
          sh_q <= sh_q << 1;
          if (last_bit) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_cmd_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CMD_OFFSET  = 0,
  parameter int STAT_OFFSET = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              done_rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              start_o,
  output mdio_req_t         req_o,
  output logic              wr_flag_o,
  output logic              rd_flag_o,
  output logic              st_rd_o
);
  logic [WORD_W-1:0] cmd_q, status_w, rdata_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              wr_done_q, rd_done_q, rvalid_q;
  logic              cmd_hit, st_rd, rd_req;

  assign req_o   = decode_cmd(bus_wdata_i);
  assign cmd_hit = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(CMD_OFFSET));
  assign start_o = cmd_hit && !busy_i && (req_o.op != OP_NONE);
  assign rd_req  = bus_valid_i && !bus_write_i;
  assign st_rd   = rd_req && (bus_addr_i == ADDR_W'(STAT_OFFSET));

  always_comb begin
    status_w                         = '0;
    status_w[ST_WR_DONE]             = wr_done_q;
    status_w[ST_RD_DONE]             = rd_done_q;
    status_w[ST_BUSY]                = busy_i;
    status_w[ST_DATA_LSB +: DATA_W]  = rd_data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      rd_data_q <= '0;
      wr_done_q <= 1'b0;
      rd_done_q <= 1'b0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      if (start_o) cmd_q <= bus_wdata_i;
      if (done_i && done_rd_i) rd_data_q <= rdata_i;
      // a completion in the same cycle as a status read is kept
      if (done_i && !done_rd_i) wr_done_q <= 1'b1;
      else if (st_rd)           wr_done_q <= 1'b0;
      if (done_i && done_rd_i)  rd_done_q <= 1'b1;
      else if (st_rd)           rd_done_q <= 1'b0;
      rvalid_q <= rd_req;
      if (rd_req) begin
        if (bus_addr_i == ADDR_W'(CMD_OFFSET))  rdata_q <= cmd_q;
        else if (st_rd)                         rdata_q <= status_w;
        else                                    rdata_q <= '0;
      end
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign wr_flag_o    = wr_done_q;
  assign rd_flag_o    = rd_done_q;
  assign st_rd_o      = st_rd;

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_DIV     = 32,
  parameter int ADDR_W      = 4,
  parameter int CMD_OFFSET  = 0,
  parameter int STAT_OFFSET = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic              eng_busy, eng_done, eng_done_rd, eng_start;
  logic              tick_rise, tick_fall;
  logic              wr_flag, rd_flag, st_rd;
  logic [DATA_W-1:0] eng_rdata;
  mdio_req_t         eng_req;

  mdio_host_regs #(
    .ADDR_W     (ADDR_W),
    .CMD_OFFSET (CMD_OFFSET),
    .STAT_OFFSET(STAT_OFFSET)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_rvalid_o(bus_rvalid_o),
    .busy_i      (eng_busy),
    .done_i      (eng_done),
    .done_rd_i   (eng_done_rd),
    .rdata_i     (eng_rdata),
    .start_o     (eng_start),
    .req_o       (eng_req),
    .wr_flag_o   (wr_flag),
    .rd_flag_o   (rd_flag),
    .st_rd_o     (st_rd)
  );

  mdio_clk_gen #(.DIV(CLK_DIV)) u_clk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (eng_busy),
    .mdc_o (mdc_o),
    .rise_o(tick_rise),
    .fall_o(tick_fall)
  );

  mdio_frame_eng u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (eng_start),
    .req_i    (eng_req),
    .rise_i   (tick_rise),
    .fall_i   (tick_fall),
    .mdio_i   (mdio_i),
    .busy_o   (eng_busy),
    .done_o   (eng_done),
    .done_rd_o(eng_done_rd),
    .rdata_o  (eng_rdata),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o)
  );

endmodule

// File: rtl/mdio_cmd_chk.sv
module mdio_cmd_chk #(
  parameter int CLK_DIV = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mdc_i,
  input logic mdio_i,
  input logic mdio_oe_i,
  input logic busy_i,
  input logic start_i,
  input logic done_i,
  input logic done_rd_i,
  input logic wr_flag_i,
  input logic rd_flag_i,
  input logic st_rd_i
);
  localparam int FRAME_CYC = 64 * CLK_DIV;
  localparam int CYC_W     = $clog2(FRAME_CYC) + 1;

  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cyc_q <= '0;
    else if (!busy_i) cyc_q <= '0;
    else              cyc_q <= cyc_q + 1'b1;
  end

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_i);  // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !mdio_oe_i));  // R10

  AST_DATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && !$fell(mdc_i)) |-> $stable(mdio_i));  // R8

  AST_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (cyc_q == CYC_W'(FRAME_CYC - 1))) |=> !busy_i);  // R9

  AST_FRAME_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (cyc_q < CYC_W'(FRAME_CYC - 1))) |=> busy_i);  // R9

  AST_WR_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !done_rd_i) |=> wr_flag_i);  // R3

  AST_RD_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && done_rd_i) |=> rd_flag_i);  // R3

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd_i && !done_i) |=> (!wr_flag_i && !rd_flag_i));  // R4

endmodule

bind mdio_cmd_engine mdio_cmd_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mdc_i    (mdc_o),
  .mdio_i   (mdio_o),
  .mdio_oe_i(mdio_oe_o),
  .busy_i   (eng_busy),
  .start_i  (eng_start),
  .done_i   (eng_done),
  .done_rd_i(eng_done_rd),
  .wr_flag_i(wr_flag),
  .rd_flag_i(rd_flag),
  .st_rd_i  (st_rd)
);

// File: tb/mdio_cmd_engine_tb.sv
`timescale 1ns/1ps
module mdio_cmd_engine_tb;
  localparam int CLK_P  = 10;
  localparam int DIV    = 32;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CMD  = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  mdio_cmd_engine #(.CLK_DIV(DIV), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic logic [15:0] init_val(input logic [9:0] a);
    return 16'({6'd0, a} * 16'h9E37) ^ 16'h5A5A;
  endfunction

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  function automatic logic [31:0] mk_cmd(input bit rd, input bit wr, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] d);
    return {d, 1'b0, rd, wr, rg, 3'b000, phy};
  endfunction

  // PHY model and expected model
  logic [15:0] phy_mem [1024];
  logic [15:0] exp_mem [1024];
  logic [63:0] cap = '0, oe_cap = '0, last_frame = '0, last_oe = '0;
  int rise_cnt = 0, frame_cnt = 0;
  bit cur_rd = 0;
  logic [9:0] cur_addr = '0;
  longint t_prev = 0, period = 0;
  int oe_cycles = 0;

  always @(posedge mdc) begin
    cap    = {cap[62:0], mdio_o};
    oe_cap = {oe_cap[62:0], mdio_oe};
    if (rise_cnt != 0) period = longint'($time) - t_prev;
    t_prev = longint'($time);
    if (rise_cnt == 45) begin
      cur_rd   = (cap[11:10] == 2'b10);
      cur_addr = {cap[9:5], cap[4:0]};
    end
    if (rise_cnt == 63) begin
      if (!cur_rd) phy_mem[cur_addr] = cap[15:0];
      last_frame = cap;
      last_oe    = oe_cap;
      frame_cnt++;
      rise_cnt = 0;
    end else begin
      rise_cnt++;
    end
  end

  always @(negedge mdc) begin
    if (cur_rd && rise_cnt >= 48 && rise_cnt <= 63)
      mdio_i = phy_mem[cur_addr][15 - (rise_cnt - 48)];
    else
      mdio_i = 1'b1;
  end

  always @(negedge clk) if (mdio_oe) oe_cycles++;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic poll_done(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 4000; i++) begin
      bus_rd(A_STAT, st);
      if (st[1:0] != 2'b00) break;
    end
    check(st[1:0] != 2'b00, "R3 completion seen", {32'd0, st}, 64'd1);
  endtask

  task automatic run_txn(input logic [31:0] cmd, output logic [31:0] st);
    logic [31:0] junk;
    bus_rd(A_STAT, junk);
    oe_cycles = 0;
    bus_wr(A_CMD, cmd);
    poll_done(st);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [31:0] st;
    int fc;
    fc = frame_cnt;
    run_txn(mk_cmd(0, 1, phy, rg, d), st);
    exp_mem[{phy, rg}] = d;
    check(st[1:0] == 2'b01, "R3 write-done only", {62'd0, st[1:0]}, 64'd1);
    check(frame_cnt == fc + 1 && last_frame == exp_frame(0, phy, rg, d),
          "R1 write frame", last_frame, exp_frame(0, phy, rg, d));
    check(last_oe == 64'hFFFF_FFFF_FFFF_FFFF, "R1 write drives all bits", last_oe, '1);
  endtask

  task automatic do_read(input logic [31:0] cmd);
    logic [31:0] st;
    logic [4:0] phy, rg;
    logic [63:0] ef;
    int fc;
    phy = cmd[4:0]; rg = cmd[12:8];
    fc = frame_cnt;
    run_txn(cmd, st);
    ef = exp_frame(1, phy, rg, 16'h0);
    check(st[1:0] == 2'b10, "R3 read-done only", {62'd0, st[1:0]}, 64'd2);
    check(frame_cnt == fc + 1 && last_frame[63:18] == ef[63:18],
          "R2 read frame header", last_frame, ef);
    check(last_oe == {{46{1'b1}}, 18'd0}, "R2 read releases line", last_oe, {{46{1'b1}}, 18'd0});
    check(st[31:16] == exp_mem[{phy, rg}], "R2 read data", {48'd0, st[31:16]},
          {48'd0, exp_mem[{phy, rg}]});
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] st, rd;
    int fc;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) begin
      phy_mem[i] = init_val(10'(i));
      exp_mem[i] = init_val(10'(i));
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
    bus_rd(A_STAT, st);
    check(st == 32'd0, "R10 status after reset", {32'd0, st}, 64'd0);
    bus_rd(A_CMD, st);
    check(st == 32'd0, "R11 command after reset", {32'd0, st}, 64'd0);

    // R1 directed write, R8 period, R9 length
    do_write(5'd3, 5'd5, 16'hA5C3);
    check(period == longint'(DIV * CLK_P), "R8 mdc period", 64'(period), 64'(DIV * CLK_P));
    check(oe_cycles == 64 * DIV, "R9 busy length", 64'(oe_cycles), 64'(64 * DIV));
    bus_rd(A_STAT, st);
    check(st[2:0] == 3'b000, "R4 flags cleared", {61'd0, st[2:0]}, 64'd0);
    bus_rd(A_CMD, st);
    check(st == mk_cmd(0, 1, 5'd3, 5'd5, 16'hA5C3), "R11 command readback", {32'd0, st},
          {32'd0, mk_cmd(0, 1, 5'd3, 5'd5, 16'hA5C3)});

    // R2 directed read of the written register
    do_read(mk_cmd(1, 0, 5'd3, 5'd5, 16'h0));
    bus_rd(A_STAT, st);
    check(st[1:0] == 2'b00, "R4 read-done cleared", {62'd0, st[1:0]}, 64'd0);

    // R3 busy, R5 command while busy is dropped
    fc = frame_cnt;
    bus_wr(A_CMD, mk_cmd(0, 1, 5'd7, 5'd2, 16'h1357));
    exp_mem[{5'd7, 5'd2}] = 16'h1357;
    bus_rd(A_STAT, st);
    check(st[2] == 1'b1, "R3 busy bit", {63'd0, st[2]}, 64'd1);
    bus_wr(A_CMD, mk_cmd(0, 1, 5'd9, 5'd9, 16'hFFFF));
    poll_done(st);
    repeat (3 * 64 * DIV) @(negedge clk);
    check(frame_cnt == fc + 1, "R5 no second frame", 64'(frame_cnt - fc), 64'd1);
    check(last_frame == exp_frame(0, 5'd7, 5'd2, 16'h1357), "R5 first frame kept",
          last_frame, exp_frame(0, 5'd7, 5'd2, 16'h1357));
    bus_rd(A_CMD, rd);
    check(rd == mk_cmd(0, 1, 5'd7, 5'd2, 16'h1357), "R5 command reg unchanged",
          {32'd0, rd}, {32'd0, mk_cmd(0, 1, 5'd7, 5'd2, 16'h1357)});
    bus_rd(A_STAT, st);

    // R6 both command bits: read wins, write data not sent
    do_read(mk_cmd(1, 1, 5'd7, 5'd2, 16'h0BAD));
    do_read(mk_cmd(1, 0, 5'd7, 5'd2, 16'h0));
    check(phy_mem[{5'd7, 5'd2}] == 16'h1357, "R6 no write performed",
          {48'd0, phy_mem[{5'd7, 5'd2}]}, 64'h1357);

    // R7 no command bit
    fc = frame_cnt;
    bus_wr(A_CMD, mk_cmd(0, 0, 5'd1, 5'd1, 16'h2222));
    bus_rd(A_STAT, st);
    check(st[2:0] == 3'b000, "R7 not busy", {61'd0, st[2:0]}, 64'd0);
    repeat (2 * 64 * DIV) @(negedge clk);
    check(frame_cnt == fc && mdio_oe == 1'b0, "R7 no frame", 64'(frame_cnt - fc), 64'd0);

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [4:0] phy, rg;
      logic [15:0] d;
      int kind;
      phy  = 5'($urandom_range(0, 3));
      rg   = 5'($urandom_range(0, 7));
      d    = 16'($urandom);
      kind = $urandom_range(0, 2);
      if (kind == 0)      do_write(phy, rg, d);
      else if (kind == 1) do_read(mk_cmd(1, 0, phy, rg, 16'h0));
      else                do_read(mk_cmd(1, 1, phy, rg, d));  // R6
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule